// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a serial peripheral interface master that a processor drives through a small set of 32-bit registers on a simple word-addressed read/write bus. Software writes bytes into a 16-entry transmit queue. A shift engine sends each byte out as one 8-bit frame and places the byte it clocks in at the same time into a 16-entry receive queue, where software reads it back. Clock polarity, clock phase, bit order and an internal loopback path are chosen in a control register. The serial clock runs at a fixed fraction of the system clock, one bit taking `2*CLK_DIV` system cycles.

Device selects are active low, one bit per device. Software writes them directly. When the manual-select control bit is clear, they are shown on the pins only while a frame is being shifted. A hold-off bit in the control register keeps the engine from starting, so that software can fill the queue first. Writing a key value to the reset register returns the whole block to its reset state. Event flags feed one interrupt line, through a per-bit enable and a global enable.

The shift engine is a four-state machine. `SH_IDLE` moves to `SH_LEAD` when it pops a byte. `SH_LEAD` is the first half of a bit and moves to `SH_TRAIL` when its half-period counter runs out, sampling the input at that moment. `SH_TRAIL` is the second half of the bit: it returns to `SH_LEAD` with the next bit on the output, or moves to `SH_FINISH` after the eighth bit. `SH_FINISH` pushes the received byte and goes back to `SH_IDLE`. A software reset forces `SH_IDLE` from any state.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the registers read back as follows. Control (byte offset 0x60) is 0x180: hold-off bit 8 and manual-select bit 7 set. Status (0x64) is 0x25, with bit 0 = receive empty, bit 1 = receive full, bit 2 = transmit empty, bit 3 = transmit full, bit 4 = mode fault (always 0) and bit 5 = slave-mode select (always 1). Select (0x70) is all ones. Global enable (0x1C), interrupt flags (0x20), interrupt enables (0x28) and both occupancy registers read 0.
- R2: A frame starts only when control bit 1 (enable) and bit 2 (master) are set, bit 8 (hold-off) is clear, and the transmit queue holds a byte. Otherwise queued bytes stay queued.
- R3: A write to the transmit data register (0x68) appends bits [7:0] to the queue. A write to a full queue (16 bytes) is dropped. The occupancy registers (0x74 transmit, 0x78 receive) return the byte count minus one in bits [3:0], and 0 when the queue is empty.
- R4: The idle serial clock level equals control bit 3 (CPOL). With control bit 4 (CPHA) clear, input is sampled on the first clock edge of each bit. With CPHA set, input is sampled on the second edge. Each 8-bit frame produces exactly 16 clock edges.
- R5: Bits are sent and received most significant first. Control bit 9 makes the order least significant first.
- R6: With control bit 0 (loopback) set, the serial output feeds the serial input internally, so each sent byte arrives unchanged in the receive queue.
- R7: Each popped byte pushes exactly one received byte. Reading the receive data register (0x6C) pops the oldest byte. A read while the queue is empty returns 0.
- R8: A received byte that arrives while the receive queue is full is dropped, and interrupt flag bit 5 is set. Interrupt flag bit 4 is set when the receive queue becomes full.
- R9: Writing control with bit 5 set empties the transmit queue in one cycle. Writing control with bit 6 set empties the receive queue. Both bits read back as 0.
- R10: With manual select (control bit 7) set, the select pins follow the select register; clearing bit n selects device n. With bit 7 clear, the pins read all ones except while a frame is being shifted, when they follow the register.
- R11: Writing 0x0000000A to byte offset 0x40 resets every register and both queues. Any other value written there has no effect.
- R12: Interrupt flag bit 8 is set on each received byte that is stored. Bit 2 is set when a frame ends with the transmit queue empty. Bit 6 is set when the transmit occupancy falls to half the depth. Writing 1 to a flag clears it. The interrupt output is high when bit 31 of the global enable is set and some flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NSS | Active-low device selects |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. A read strobe and a write strobe are never high in the same cycle. A software reset write is not issued together with other traffic. The polarity bit is not changed while a frame is in flight, because the idle-clock check only tolerates clock movement when polarity itself changes. The bench meets all three. It drives one bus access per cycle, separated by idle cycles. It changes the clock mode only when the transmit queue is empty and the engine has had time to return to idle, and it re-arms its serial device model after each mode change, so the idle-level shift that a polarity write causes is not counted as a frame edge.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_GIE   = 7'h1C;
    localparam logic [ADDR_W-1:0] A_ISR   = 7'h20;
    localparam logic [ADDR_W-1:0] A_IER   = 7'h28;
    localparam logic [ADDR_W-1:0] A_SRST  = 7'h40;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h60;
    localparam logic [ADDR_W-1:0] A_STAT  = 7'h64;
    localparam logic [ADDR_W-1:0] A_TXD   = 7'h68;
    localparam logic [ADDR_W-1:0] A_RXD   = 7'h6C;
    localparam logic [ADDR_W-1:0] A_SSEL  = 7'h70;
    localparam logic [ADDR_W-1:0] A_TXOCC = 7'h74;
    localparam logic [ADDR_W-1:0] A_RXOCC = 7'h78;

    localparam logic [31:0] SRST_KEY = 32'h0000_000A;

    localparam int CTRL_W   = 10;
    localparam int CB_LOOP  = 0;
    localparam int CB_SPE   = 1;
    localparam int CB_MST   = 2;
    localparam int CB_CPOL  = 3;
    localparam int CB_CPHA  = 4;
    localparam int CB_TXRST = 5;
    localparam int CB_RXRST = 6;
    localparam int CB_MAN   = 7;
    localparam int CB_INH   = 8;
    localparam int CB_LSB   = 9;
    localparam logic [CTRL_W-1:0] CTRL_RST = 10'h180;

    localparam int IRQ_W     = 9;
    localparam int IB_TXE    = 2;
    localparam int IB_RXFULL = 4;
    localparam int IB_OVR    = 5;
    localparam int IB_HALF   = 6;
    localparam int IB_RXNE   = 8;
    localparam int GIE_BIT   = 31;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LEAD,
        SH_TRAIL,
        SH_FINISH
    } sh_state_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = cnt_q;
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == LAST) ? '0 : wp_q + PW'(1);
            end
            if (do_pop) begin
                rp_q <= (rp_q == LAST) ? '0 : rp_q + PW'(1);
            end
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // R3: a push into a full queue without a pop leaves it full
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));

    // R9: a clear leaves the queue empty on the next cycle
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R7: a lone pop removes exactly one entry
    a_r7_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !clr) |=> (count == $past(count) - CW'(1)));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int CLK_DIV = 2,
    localparam int DW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       go_ok,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       lsb_first,
    input  logic       loopback,
    input  logic       tx_empty,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       tx_pop,
    output logic       rx_push,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    output logic       busy
);

    localparam logic [DW-1:0] RELOAD = DW'(CLK_DIV - 1);

    sh_state_t     state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_sh, rx_sh;
    logic          half_end;
    logic          in_bit;

    assign half_end = (cnt_q == '0);
    assign mosi     = lsb_first ? tx_sh[0] : tx_sh[7];
    assign in_bit   = loopback ? mosi : miso;
    assign rx_byte  = rx_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
        end else if (abort) begin
            state_q <= SH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:   if (tx_pop) state_d = SH_LEAD;
            SH_LEAD:   if (half_end) state_d = SH_TRAIL;
            SH_TRAIL:  if (half_end) state_d = (bit_q == 3'd7) ? SH_FINISH : SH_LEAD;
            SH_FINISH: state_d = SH_IDLE;
            default:   state_d = SH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        sclk    = cpol;
        busy    = 1'b1;
        unique case (state_q)
            SH_IDLE: begin
                busy   = 1'b0;
                tx_pop = go_ok && !tx_empty && !abort;
            end
            SH_LEAD:   sclk = cpol ^ cpha;
            SH_TRAIL:  sclk = ~(cpol ^ cpha);
            SH_FINISH: rx_push = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // datapath: half-period counter, bit index, shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (abort) begin
            cnt_q <= '0;
            bit_q <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    if (tx_pop) begin
                        tx_sh <= tx_byte;
                        cnt_q <= RELOAD;
                        bit_q <= '0;
                    end
                end
                SH_LEAD: begin
                    if (half_end) begin
                        rx_sh <= lsb_first ? {in_bit, rx_sh[7:1]} : {rx_sh[6:0], in_bit};
                        cnt_q <= RELOAD;
                    end else begin
                        cnt_q <= cnt_q - DW'(1);
                    end
                end
                SH_TRAIL: begin
                    if (half_end) begin
                        cnt_q <= RELOAD;
                        bit_q <= bit_q + 3'd1;
                        tx_sh <= lsb_first ? {1'b0, tx_sh[7:1]} : {tx_sh[6:0], 1'b0};
                    end else begin
                        cnt_q <= cnt_q - DW'(1);
                    end
                end
                SH_FINISH: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // R7: one received byte per frame, never two pushes in a row
    a_r7_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    // R2: a pop always launches a frame
    a_r2_pop_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !abort) |=> busy);

    // R4: while idle the clock only moves when polarity changes
    a_r4_idle_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE && $past(state_q) == SH_IDLE && $stable(cpol)) |-> $stable(sclk));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int NSS     = 32,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NSS-1:0]    spi_ss_n,
    output logic              irq
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int OCCW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic              gie_q;
    logic [IRQ_W-1:0]  ier_q, isr_q, isr_set, isr_clr;
    logic [NSS-1:0]    ss_q;
    logic              rx_full_q, tx_half_q;

    logic sw_rst, wr_ctrl, tx_clr, rx_clr, tx_push, rx_pop;
    logic [7:0]    tx_dout, rx_dout, sh_rx_byte;
    logic [CW-1:0] tx_count, rx_count;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic sh_pop, sh_push, sh_busy, tx_half;

    assign sw_rst  = bus_wr && (bus_addr == A_SRST) && (bus_wdata == SRST_KEY);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign tx_clr  = sw_rst || (wr_ctrl && bus_wdata[CB_TXRST]);
    assign rx_clr  = sw_rst || (wr_ctrl && bus_wdata[CB_RXRST]);
    assign tx_push = bus_wr && (bus_addr == A_TXD);
    assign rx_pop  = bus_rd && (bus_addr == A_RXD);
    assign tx_half = (tx_count <= CW'(DEPTH / 2));

    spim_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .din(bus_wdata[7:0]),
        .pop(sh_pop), .dout(tx_dout),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(sh_push), .din(sh_rx_byte),
        .pop(rx_pop), .dout(rx_dout),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    spim_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(sw_rst),
        .go_ok(ctrl_q[CB_SPE] && ctrl_q[CB_MST] && !ctrl_q[CB_INH]),
        .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]),
        .lsb_first(ctrl_q[CB_LSB]), .loopback(ctrl_q[CB_LOOP]),
        .tx_empty(tx_empty), .tx_byte(tx_dout), .miso(spi_miso),
        .tx_pop(sh_pop), .rx_push(sh_push), .rx_byte(sh_rx_byte),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy)
    );

    // interrupt events
    always_comb begin
        isr_set            = '0;
        isr_set[IB_TXE]    = sh_push && tx_empty;
        isr_set[IB_RXFULL] = rx_full && !rx_full_q;
        isr_set[IB_OVR]    = sh_push && rx_full;
        isr_set[IB_HALF]   = tx_half && !tx_half_q;
        isr_set[IB_RXNE]   = sh_push && !rx_full;
        isr_clr            = (bus_wr && bus_addr == A_ISR) ? bus_wdata[IRQ_W-1:0] : '0;
    end

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= CTRL_RST;
            gie_q     <= 1'b0;
            ier_q     <= '0;
            isr_q     <= '0;
            ss_q      <= '1;
            rx_full_q <= 1'b0;
            tx_half_q <= 1'b1;
        end else if (sw_rst) begin
            ctrl_q    <= CTRL_RST;
            gie_q     <= 1'b0;
            ier_q     <= '0;
            isr_q     <= '0;
            ss_q      <= '1;
            rx_full_q <= 1'b0;
            tx_half_q <= 1'b1;
        end else begin
            rx_full_q <= rx_full;
            tx_half_q <= tx_half;
            isr_q     <= (isr_q & ~isr_clr) | isr_set;
            if (wr_ctrl) begin
                ctrl_q           <= bus_wdata[CTRL_W-1:0];
                ctrl_q[CB_TXRST] <= 1'b0;
                ctrl_q[CB_RXRST] <= 1'b0;
            end
            if (bus_wr && bus_addr == A_GIE)  gie_q <= bus_wdata[GIE_BIT];
            if (bus_wr && bus_addr == A_IER)  ier_q <= bus_wdata[IRQ_W-1:0];
            if (bus_wr && bus_addr == A_SSEL) ss_q  <= bus_wdata[NSS-1:0];
        end
    end

    function automatic logic [31:0] occ(input logic [CW-1:0] c);
        logic [CW-1:0] m;
        m = (c == '0) ? '0 : c - CW'(1);
        return 32'(m[OCCW-1:0]);
    endfunction

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_GIE:   bus_rdata[GIE_BIT] = gie_q;
            A_ISR:   bus_rdata[IRQ_W-1:0] = isr_q;
            A_IER:   bus_rdata[IRQ_W-1:0] = ier_q;
            A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
            A_STAT:  bus_rdata[5:0] = {1'b1, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
            A_RXD:   bus_rdata[7:0] = rx_empty ? 8'h00 : rx_dout;
            A_SSEL:  bus_rdata[NSS-1:0] = ss_q;
            A_TXOCC: bus_rdata = occ(tx_count);
            A_RXOCC: bus_rdata = occ(rx_count);
            default: bus_rdata = '0;
        endcase
    end

    assign spi_ss_n = (ctrl_q[CB_MAN] || sh_busy) ? ss_q : '1;
    assign irq      = gie_q && |(isr_q & ier_q);

    // R11: the key write returns control, selects and flags to reset values
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (ctrl_q == CTRL_RST && ss_q == '1 && isr_q == '0));

    // R12: writing 1 to the receive-not-empty flag clears it unless it is re-set
    a_r12_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ISR && bus_wdata[IB_RXNE] && !sh_push && !sw_rst)
        |=> !isr_q[IB_RXNE]);

endmodule

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;

    localparam int NSS     = 32;
    localparam int CLK_DIV = 2;
    localparam int BW      = 2 + 16 * CLK_DIV + 6;

    localparam logic [6:0] GIE = 7'h1C, ISR = 7'h20, IER = 7'h28, SRST = 7'h40,
                           CTRL = 7'h60, STAT = 7'h64, TXD = 7'h68, RXD = 7'h6C,
                           SSEL = 7'h70, TXOCC = 7'h74, RXOCC = 7'h78;
    localparam logic [31:0] LOOP = 32'h1, SPE = 32'h2, MST = 32'h4, CPOL = 32'h8,
                            CPHA = 32'h10, TXR = 32'h20, RXR = 32'h40, MAN = 32'h80,
                            INH = 32'h100, LSB = 32'h200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic spi_miso = 1'b0;
    logic spi_sclk, spi_mosi, irq;
    logic [NSS-1:0] spi_ss_n;

    int checks = 0;
    int fails  = 0;

    always #10ns clk = ~clk;

    spim_ctrl #(.DEPTH(16), .NSS(NSS), .CLK_DIV(CLK_DIV)) u_spim_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_ss_n(spi_ss_n), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1ns;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // serial device model
    logic m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    logic [7:0] s_tx = '0, s_rx = '0;
    int s_samp = 0, s_shift = 0, s_edges = 0;

    function automatic logic sbit(input logic [7:0] b, input int k, input logic l);
        return l ? b[k] : b[7-k];
    endfunction

    task automatic slave_arm(input logic cp, input logic ph, input logic l, input logic [7:0] b);
        m_cpol = cp; m_cpha = ph; m_lsb = l;
        s_tx = b; s_rx = '0; s_samp = 0; s_shift = 0; s_edges = 0;
        spi_miso = ph ? 1'b0 : sbit(b, 0, l);
    endtask

    always @(spi_sclk) begin
        s_edges++;
        if (spi_sclk == ~(m_cpol ^ m_cpha)) begin
            if (s_samp < 8) begin
                if (m_lsb) s_rx[s_samp] = spi_mosi;
                else       s_rx[7-s_samp] = spi_mosi;
            end
            s_samp++;
        end else begin
            if ((m_cpha ? s_shift : s_shift + 1) < 8)
                spi_miso = sbit(s_tx, m_cpha ? s_shift : s_shift + 1, m_lsb);
            s_shift++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c;
        logic [7:0]  tb, sb;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        rd(CTRL, v);  chk("R1 ctrl", v, 32'h180);
        rd(STAT, v);  chk("R1 status", v, 32'h25);
        rd(SSEL, v);  chk("R1 select", v, 32'hFFFF_FFFF);
        rd(GIE, v);   chk("R1 gie", v, 0);
        rd(ISR, v);   chk("R1 isr", v, 0);
        rd(IER, v);   chk("R1 ier", v, 0);
        rd(TXOCC, v); chk("R1 txocc", v, 0);
        rd(RXOCC, v); chk("R1 rxocc", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 ss pins", spi_ss_n, 32'hFFFF_FFFF);

        // R10 manual select
        wr(SSEL, 32'hFFFF_FFDF); idle(1);
        chk("R10 manual pins", spi_ss_n, 32'hFFFF_FFDF);

        // R2 start gating
        wr(CTRL, MST | MAN | LOOP);
        wr(TXD, 32'h11); idle(BW);
        rd(STAT, v); chk("R2 no enable", v, 32'h21);
        wr(CTRL, SPE | MAN | LOOP); idle(BW);
        rd(STAT, v); chk("R2 no master", v, 32'h21);
        wr(CTRL, SPE | MST | MAN | LOOP | INH); idle(BW);
        rd(STAT, v); chk("R2 hold-off", v, 32'h21);
        wr(CTRL, SPE | MST | MAN | LOOP); idle(BW);
        rd(STAT, v); chk("R2 released", v, 32'h24);
        rd(RXD, v);  chk("R7 byte back", v, 32'h11);
        rd(RXD, v);  chk("R7 empty read", v, 0);

        // R9 queue resets
        c = SPE | MST | MAN | LOOP | INH;
        wr(CTRL, c);
        for (int i = 0; i < 3; i++) wr(TXD, 32'(i + 1));
        rd(TXOCC, v); chk("R3 occupancy 3", v, 2);
        wr(CTRL, c | TXR);
        rd(STAT, v); chk("R9 tx emptied", v & 32'h4, 32'h4);
        rd(CTRL, v); chk("R9 tx bit reads 0", v, c);
        wr(CTRL, SPE | MST | MAN | LOOP);
        wr(TXD, 32'h21); wr(TXD, 32'h22); idle(2 * BW);
        rd(STAT, v); chk("R9 rx filled", v & 32'h1, 0);
        wr(CTRL, SPE | MST | MAN | LOOP | RXR);
        rd(STAT, v); chk("R9 rx emptied", v & 32'h1, 32'h1);
        rd(CTRL, v); chk("R9 rx bit reads 0", v, SPE | MST | MAN | LOOP);

        // R3 full transmit queue
        wr(ISR, 32'h1FF);
        wr(CTRL, c);
        for (int i = 0; i < 16; i++) wr(TXD, 32'h40 + 32'(i));
        rd(STAT, v);  chk("R3 tx full flag", v & 32'h8, 32'h8);
        rd(TXOCC, v); chk("R3 occupancy 16", v, 15);
        wr(TXD, 32'hEE);
        rd(TXOCC, v); chk("R3 drop on full", v, 15);
        wr(CTRL, SPE | MST | MAN | LOOP); idle(16 * BW);
        rd(ISR, v);   chk("R12 half-empty flag", (v >> 6) & 1, 1);
        rd(RXOCC, v); chk("R3 rx occupancy 16", v, 15);
        for (int i = 0; i < 16; i++) begin
            rd(RXD, v); chk("R3 order", v, 32'h40 + 32'(i));
        end
        rd(STAT, v); chk("R3 extra byte absent", v & 32'h1, 32'h1);

        // R8 overrun
        wr(ISR, 32'h1FF);
        wr(CTRL, c);
        for (int i = 0; i < 16; i++) wr(TXD, 32'h80 + 32'(i));
        wr(CTRL, SPE | MST | MAN | LOOP); idle(16 * BW);
        rd(STAT, v); chk("R8 rx full status", v & 32'h2, 32'h2);
        rd(ISR, v);  chk("R8 rx full flag", (v >> 4) & 1, 1);
        chk("R8 no overrun yet", (v >> 5) & 1, 0);
        wr(TXD, 32'h5A); idle(BW);
        rd(ISR, v);  chk("R8 overrun flag", (v >> 5) & 1, 1);
        for (int i = 0; i < 16; i++) begin
            rd(RXD, v); chk("R8 kept bytes", v, 32'h80 + 32'(i));
        end
        rd(STAT, v); chk("R8 dropped byte", v & 32'h1, 32'h1);

        // R12 interrupt path
        wr(ISR, 32'h1FF);
        wr(IER, 32'h100);
        wr(TXD, 32'h3C); idle(BW);
        chk("R12 gated by gie", 32'(irq), 0);
        rd(ISR, v); chk("R12 rx-not-empty flag", (v >> 8) & 1, 1);
        chk("R12 tx-empty flag", (v >> 2) & 1, 1);
        wr(GIE, 32'h8000_0000); idle(1);
        chk("R12 irq raised", 32'(irq), 1);
        wr(ISR, 32'h100); idle(1);
        chk("R12 w1c lowers irq", 32'(irq), 0);
        rd(RXD, v); chk("R7 loop byte", v, 32'h3C);
        wr(GIE, 0); wr(IER, 0);

        // R10 automatic select
        wr(CTRL, SPE | MST | LOOP);
        wr(SSEL, 32'hFFFF_FFFE); idle(1);
        chk("R10 auto idle", spi_ss_n, 32'hFFFF_FFFF);
        wr(TXD, 32'h77); idle(6);
        chk("R10 auto active", spi_ss_n, 32'hFFFF_FFFE);
        idle(BW);
        chk("R10 auto released", spi_ss_n, 32'hFFFF_FFFF);
        rd(RXD, v);

        // R4 R5 R7: all clock modes and both orders against the device model
        for (int cfg = 0; cfg < 8; cfg++) begin
            c = SPE | MST | MAN;
            if (cfg[0]) c |= CPOL;
            if (cfg[1]) c |= CPHA;
            if (cfg[2]) c |= LSB;
            wr(CTRL, c); idle(2);
            chk("R4 idle level", 32'(spi_sclk), 32'(cfg[0]));
            for (int j = 0; j < 3; j++) begin
                tb = 8'(cfg * 37 + j * 91 + 5);
                sb = ~tb ^ 8'(j * 17);
                slave_arm(cfg[0], cfg[1], cfg[2], sb);
                wr(TXD, 32'(tb)); idle(BW);
                rd(RXD, v);
                chk("R5 received byte", v, 32'(sb));
                chk("R5 sent byte", 32'(s_rx), 32'(tb));
                chk("R4 edge count", 32'(s_edges), 16);
            end
        end

        // R6 loopback over every byte value, both orders
        for (int b = 0; b < 16; b++) begin
            c = SPE | MST | MAN | LOOP | ((b % 2 == 1) ? LSB : 0);
            wr(CTRL, c | INH);
            for (int i = 0; i < 16; i++) wr(TXD, 32'(b * 16 + i));
            wr(CTRL, c); idle(16 * BW);
            for (int i = 0; i < 16; i++) begin
                rd(RXD, v); chk("R6 loopback value", v, 32'(b * 16 + i));
            end
        end

        // R11 software reset
        wr(CTRL, SPE | MST | LOOP | CPOL);
        wr(SSEL, 32'h0F0F_0F0F);
        wr(SRST, 32'hB);
        rd(CTRL, v); chk("R11 wrong key ignored", v, SPE | MST | LOOP | CPOL);
        rd(SSEL, v); chk("R11 select kept", v, 32'h0F0F_0F0F);
        wr(SRST, 32'hA);
        rd(CTRL, v); chk("R11 ctrl reset", v, 32'h180);
        rd(SSEL, v); chk("R11 select reset", v, 32'hFFFF_FFFF);
        rd(STAT, v); chk("R11 status reset", v, 32'h25);
        chk("R11 clock idle", 32'(spi_sclk), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule